// File: doc/BRIEF.md
# Packed Colour Palette with Channel Expansion

This block holds a 256-entry colour palette packed two entries to a 32-bit word, so the whole table occupies 128 words. A bus-side write port stores a full word, which updates two neighbouring palette entries at once. A bus-side read port returns the stored word exactly as it was written.

A separate pixel lookup port takes an 8-bit colour index and returns 8-bit red, green and blue values one clock later. Each 16-bit entry carries three 5-bit colour fields and one intensity bit. Each field is widened to 8 bits by a left shift of three, and the intensity bit plays no part in the result. A per-lookup swap input exchanges the red and blue outputs for panels that expect blue-first ordering.

Top module: `palette_unpack`

## Requirements
- R1: While `rst` is high at a clock edge, every stored word becomes zero, and `bus_rdata` and all three pixel outputs read zero after that edge.
- R2: A word written through `bus_we`/`bus_waddr`/`bus_wdata` is returned unchanged, all 32 bits including bits 15 and 31, by a later read of the same address.
- R3: `bus_rdata` shows the word at `bus_raddr` one clock after the address is presented.
- R4: Bits [7:1] of `lut_index` select the word; bit 0 = 0 selects the entry in word bits [15:0], and bit 0 = 1 selects the entry in word bits [31:16].
- R5: With `lut_swap` low, entry bits [4:0] drive `pix_red`, bits [9:5] drive `pix_green` and bits [14:10] drive `pix_blue`, each as the 5-bit field followed by three zero bits (value shifted left by 3).
- R6: Bit 15 of an entry (the intensity bit) has no effect on any pixel output.
- R7: With `lut_swap` high, the field in entry bits [4:0] appears on `pix_blue` and the field in bits [14:10] on `pix_red`; `pix_green` is unchanged.
- R8: The pixel outputs reflect `lut_index` and `lut_swap` as sampled at the previous clock edge and hold until the next edge.
- R9: A write and a read or lookup of the same word in the same cycle return the contents from before the write; the new word is seen from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Word write enable |
| bus_waddr | input | 7 | Word address for writes |
| bus_wdata | input | 32 | Word to store (two packed entries) |
| bus_raddr | input | 7 | Word address for reads |
| bus_rdata | output | 32 | Stored word, one cycle after the address |
| lut_index | input | 8 | Palette index for pixel lookup |
| lut_swap | input | 1 | Exchange red and blue on the lookup |
| pix_red | output | 8 | Expanded red channel |
| pix_green | output | 8 | Expanded green channel |
| pix_blue | output | 8 | Expanded blue channel |

## Verification
On every cycle the assertions check that reset leaves the read port and pixel outputs at zero, that a written word comes back on a read of its address two edges later, that flipping only the swap input exchanges red and blue while green holds, and that a held index with no write keeps the pixel outputs steady. The exact field-to-channel mapping, the even/odd half selection, the disregarded intensity bit and the old-data result of a same-cycle write and lookup on one word are shown only by the bench's directed and random scenarios against its own model.

// File: rtl/palette_pkg.sv
package palette_pkg;

    localparam int WORDS    = 128;
    localparam int WORD_W   = 32;
    localparam int ENTRY_W  = 16;
    localparam int CH_W     = 5;
    localparam int OUT_W    = 8;
    localparam int NCH      = 3;
    localparam int COLOR_W  = NCH * CH_W;
    localparam int ADDR_W   = $clog2(WORDS);
    localparam int INDEX_W  = ADDR_W + 1;
    localparam int SHIFT    = OUT_W - CH_W;

    typedef struct packed {
        logic [OUT_W-1:0] red;
        logic [OUT_W-1:0] green;
        logic [OUT_W-1:0] blue;
    } rgb_t;

    function automatic logic [OUT_W-1:0] widen_field(input logic [CH_W-1:0] f);
        return {f, {SHIFT{1'b0}}};
    endfunction

endpackage

// File: rtl/palette_words.sv
module palette_words
    import palette_pkg::*;
#(
    parameter int N_WORDS = WORDS,
    parameter int W_BITS  = WORD_W,
    parameter int E_BITS  = ENTRY_W,
    parameter int C_BITS  = COLOR_W,
    localparam int A_BITS = $clog2(N_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [A_BITS-1:0] waddr,
    input  logic [W_BITS-1:0] wdata,
    input  logic [A_BITS-1:0] raddr,
    output logic [W_BITS-1:0] rdata,
    input  logic [A_BITS:0]   index,
    input  logic              swap_in,
    output logic [C_BITS-1:0] color_q,
    output logic              swap_q
);

    logic [W_BITS-1:0] mem [N_WORDS];
    logic [W_BITS-1:0] lut_word;
    logic [E_BITS-1:0] lut_half;

    assign lut_word = mem[index[A_BITS:1]];
    assign lut_half = index[0] ? lut_word[2*E_BITS-1:E_BITS] : lut_word[E_BITS-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_WORDS; i++) mem[i] <= '0;
            rdata   <= '0;
            color_q <= '0;
            swap_q  <= 1'b0;
        end else begin
            if (we) mem[waddr] <= wdata;
            rdata   <= mem[raddr];
            color_q <= lut_half[C_BITS-1:0];
            swap_q  <= swap_in;
        end
    end

    // R1: reset clears the read port
    a_r1_rdata_reset: assert property (@(posedge clk) $past(rst) |-> rdata == '0);

    // R2: a word written is read back two edges after the write
    a_r2_write_read: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) && $past(we) && raddr == $past(waddr) |=> rdata == $past(wdata, 2));

endmodule

// File: rtl/palette_expand.sv
module palette_expand
    import palette_pkg::*;
#(
    parameter int C_BITS = COLOR_W
) (
    input  logic [C_BITS-1:0] color,
    input  logic              swap,
    output rgb_t              rgb
);

    localparam int F_BITS = C_BITS / NCH;

    logic [OUT_W-1:0] chan [NCH];

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        assign chan[c] = widen_field(color[c*F_BITS +: F_BITS]);
    end

    always_comb begin
        rgb.green = chan[1];
        if (swap) begin
            rgb.red  = chan[2];
            rgb.blue = chan[0];
        end else begin
            rgb.red  = chan[0];
            rgb.blue = chan[2];
        end
    end

endmodule

// File: rtl/palette_unpack.sv
module palette_unpack
    import palette_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_waddr,
    input  logic [WORD_W-1:0]  bus_wdata,
    input  logic [ADDR_W-1:0]  bus_raddr,
    output logic [WORD_W-1:0]  bus_rdata,
    input  logic [INDEX_W-1:0] lut_index,
    input  logic               lut_swap,
    output logic [OUT_W-1:0]   pix_red,
    output logic [OUT_W-1:0]   pix_green,
    output logic [OUT_W-1:0]   pix_blue
);

    logic [COLOR_W-1:0] color_q;
    logic               swap_q;
    rgb_t               rgb;

    palette_words #(
        .N_WORDS(WORDS),
        .W_BITS (WORD_W),
        .E_BITS (ENTRY_W),
        .C_BITS (COLOR_W)
    ) u_words (
        .clk    (clk),
        .rst    (rst),
        .we     (bus_we),
        .waddr  (bus_waddr),
        .wdata  (bus_wdata),
        .raddr  (bus_raddr),
        .rdata  (bus_rdata),
        .index  (lut_index),
        .swap_in(lut_swap),
        .color_q(color_q),
        .swap_q (swap_q)
    );

    palette_expand #(.C_BITS(COLOR_W)) u_expand (
        .color(color_q),
        .swap (swap_q),
        .rgb  (rgb)
    );

    assign pix_red   = rgb.red;
    assign pix_green = rgb.green;
    assign pix_blue  = rgb.blue;

    // R1: reset clears pixel outputs
    a_r1_pix_reset: assert property (@(posedge clk)
        $past(rst) |-> (pix_red == '0 && pix_green == '0 && pix_blue == '0));

    // R7: flipping only the swap input exchanges red and blue
    a_r7_swap_exchange: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) && lut_index == $past(lut_index) && lut_swap != $past(lut_swap)
        && !$past(bus_we)
        |=> pix_red == $past(pix_blue) && pix_blue == $past(pix_red)
            && pix_green == $past(pix_green));

    // R8: held index and swap with no write keep the pixel steady
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) && $stable(lut_index) && $stable(lut_swap) && !$past(bus_we)
        |=> $stable(pix_red) && $stable(pix_green) && $stable(pix_blue));

endmodule

// File: tb/sim_palette_unpack.sv
`timescale 1ns/1ps
module sim_palette_unpack;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_we;
    logic [6:0]  bus_waddr;
    logic [31:0] bus_wdata;
    logic [6:0]  bus_raddr;
    logic [31:0] bus_rdata;
    logic [7:0]  lut_index;
    logic        lut_swap;
    logic [7:0]  pix_red, pix_green, pix_blue;

    int checks = 0;
    int errors = 0;
    logic [31:0] model [128];
    logic [31:0] exp_rd;
    logic [23:0] exp_pix;

    always #10 clk = ~clk;

    palette_unpack u0 (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_waddr(bus_waddr),
        .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
        .lut_index(lut_index), .lut_swap(lut_swap),
        .pix_red(pix_red), .pix_green(pix_green), .pix_blue(pix_blue)
    );

    function automatic logic [23:0] expect_pix(input logic [31:0] w,
                                               input logic odd, input logic sw);
        logic [15:0] e;
        logic [7:0] a, g, c;
        e = odd ? w[31:16] : w[15:0];
        a = {e[4:0], 3'b000};
        g = {e[9:5], 3'b000};
        c = {e[14:10], 3'b000};
        return sw ? {c, g, a} : {a, g, c};
    endfunction

    task automatic chk_rd(input string req);
        checks++;
        if (bus_rdata !== exp_rd) begin
            errors++;
            $display("FAIL %s rdata actual %h expected %h", req, bus_rdata, exp_rd);
        end
    endtask

    task automatic chk_pix(input string req);
        checks++;
        if ({pix_red, pix_green, pix_blue} !== exp_pix) begin
            errors++;
            $display("FAIL %s pixel actual %h expected %h", req,
                     {pix_red, pix_green, pix_blue}, exp_pix);
        end
    endtask

    // drive at a falling edge, model the next rising edge, return at the next falling edge
    task automatic cyc(input logic we, input logic [6:0] wa, input logic [31:0] wd,
                       input logic [6:0] ra, input logic [7:0] idx, input logic sw);
        bus_we = we; bus_waddr = wa; bus_wdata = wd; bus_raddr = ra;
        lut_index = idx; lut_swap = sw;
        exp_rd  = model[ra];
        exp_pix = expect_pix(model[idx[7:1]], idx[0], sw);
        if (we) model[wa] = wd;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; bus_we = 0; bus_waddr = 0; bus_wdata = 0; bus_raddr = 5;
        lut_index = 8'd9; lut_swap = 0;
        for (int i = 0; i < 128; i++) model[i] = '0;
        @(negedge clk); @(negedge clk);
        // R1: outputs zero after reset
        exp_rd = '0; exp_pix = '0;
        chk_rd("R1"); chk_pix("R1");
        rst = 1'b0;
        cyc(0, 0, 0, 7'd5, 8'd9, 0); chk_rd("R1"); chk_pix("R1");

        // R2/R6: full word with both intensity bits set
        cyc(1, 7'd10, 32'hFFFF_8000 | 32'h1234_0421, 7'd0, 8'd0, 0);
        cyc(0, 0, 0, 7'd10, 8'd20, 0); chk_rd("R2"); chk_pix("R4 even");
        // R3: rdata follows the address one cycle later
        cyc(0, 0, 0, 7'd0, 8'd21, 0); chk_rd("R3"); chk_pix("R4 odd");

        // R5: each field alone
        cyc(1, 7'd11, 32'h0000_001F, 0, 0, 0);
        cyc(0, 0, 0, 0, 8'd22, 0); chk_pix("R5 red");
        cyc(1, 7'd11, 32'h0000_03E0, 0, 8'd22, 0); chk_pix("R5");
        cyc(0, 0, 0, 0, 8'd22, 0); chk_pix("R5 green");
        cyc(1, 7'd11, 32'h0000_7C00, 0, 8'd22, 0);
        cyc(0, 0, 0, 0, 8'd22, 0); chk_pix("R5 blue");

        // R6: intensity bit toggled alone leaves the pixel unchanged
        cyc(1, 7'd12, 32'h0000_2A55, 0, 0, 0);
        cyc(0, 0, 0, 0, 8'd24, 0); chk_pix("R6");
        cyc(1, 7'd12, 32'h0000_AA55, 0, 8'd24, 0);
        cyc(0, 0, 0, 0, 8'd24, 0); chk_pix("R6");

        // R7: swap exchanges red and blue
        cyc(0, 0, 0, 0, 8'd24, 1); chk_pix("R7");
        cyc(0, 0, 0, 0, 8'd21, 1); chk_pix("R7");

        // R8: swap sampled with the index, output holds
        cyc(0, 0, 0, 0, 8'd24, 0); chk_pix("R8");
        lut_swap = 1'b1; #3; checks++;
        if ({pix_red, pix_green, pix_blue} !== exp_pix) begin
            errors++;
            $display("FAIL R8 pixel changed between edges actual %h expected %h",
                     {pix_red, pix_green, pix_blue}, exp_pix);
        end
        @(negedge clk);

        // R9: same-cycle write and read/lookup return old data
        cyc(1, 7'd30, 32'h7FFF_1111, 7'd30, 8'd60, 0); chk_rd("R9"); chk_pix("R9");
        cyc(1, 7'd30, 32'h0C63_5294, 7'd30, 8'd61, 1); chk_rd("R9"); chk_pix("R9");
        cyc(0, 0, 0, 7'd30, 8'd60, 0); chk_rd("R9"); chk_pix("R9");

        // random mix, narrow address range for collisions
        for (int n = 0; n < 400; n++) begin
            logic [6:0] wa, ra;
            logic [7:0] idx;
            wa  = 7'($urandom_range(0, 7));
            ra  = 7'($urandom_range(0, 7));
            idx = 8'($urandom_range(0, 15));
            if (n % 50 == 0) idx = 8'($urandom);
            cyc(1'($urandom), wa, $urandom, ra, idx, 1'($urandom));
            chk_rd("R2"); chk_pix("R5");
        end

        // R1: reset again clears stored words
        rst = 1'b1;
        cyc(0, 0, 0, 7'd3, 8'd7, 0);
        rst = 1'b0;
        for (int i = 0; i < 128; i++) model[i] = '0;
        for (int i = 0; i < 8; i++) begin
            cyc(0, 0, 0, 7'(i), 8'(2 * i + 1), 0); chk_rd("R1"); chk_pix("R1");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule